// File: doc/BRIEF.md
# OFDM Coarse Timing Synchroniser

This block looks for the start of an OFDM burst in a stream of complex baseband samples. A burst opens with a short training sequence that repeats with period L. The block keeps a sliding delayed autocorrelation P between each sample and the sample L positions later, and a sliding energy term R over the later half of the same window. When the normalised metric |P|²/R² rises above a programmable fraction, the block raises a detect flag on the sample stream and records a coarse estimate of where the repeated section began. The metric needs no knowledge of the training sequence, so the detection is blind.

Samples enter on one AXI-Stream style slave port and leave, unchanged and in order, on one master port together with the current correlation value, the detect flag and the latest start estimate. The correlation travels with each sample so that a later stage can take its angle for frequency correction. The period L is picked at run time from a small code, so one instance covers several OFDM standards. Any change of the code wipes the history, and detection is held off until the window is full again.

Top module: `ofdm_coarse_sync`

## Requirements
- R1: `len_code` value k selects L = 16·2^k for k = 0..5. Any code of 5 or above selects L = 512.
- R2: Each output sample carries P = Σ conj(x[k−L])·x[k] over k = n−L+1..n, where n is the index of that sample. Indices count from 0 at the first sample accepted after the last clear, and samples before that point count as zero. The real part is on `p_re` and the imaginary part on `p_im`.
- R3: P and R stay exact with full-scale inputs, −32768 included, at L = 512.
- R4: `det` is 1 only when at least 2L samples have been accepted since the last clear and |P|²·256 > thr·R². Here R = Σ|x[k]|² over the same k range as P.
- R5: On the first sample of each run of `det` = 1, `start_idx` becomes n − 2L + 1. Between runs it holds its value. Its reset value is 0.
- R6: A change of `len_code` costs one cycle with `s_ready` low. It clears the history, the sample index and the run state.
- R7: While `m_valid` is 1 and `m_ready` is 0, every output holds and `s_ready` is 0. Each accepted sample leaves exactly once, in order, with `m_i`/`m_q` equal to its input.
- R8: After reset `m_valid`, `det` and `start_idx` are 0, and `s_ready` is 1 while `len_code` is 0.
- R9: `thr` (8 bits, fraction thr/256) is sampled together with each accepted sample and may change on any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| len_code | input | 4 | Period select code |
| thr | input | 8 | Detection threshold, fraction of 256 |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted |
| s_i | input | 16 | Input in-phase, signed |
| s_q | input | 16 | Input quadrature, signed |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream ready |
| m_i | output | 16 | Output in-phase |
| m_q | output | 16 | Output quadrature |
| p_re | output | 43 | Correlation, real part, signed |
| p_im | output | 43 | Correlation, imaginary part, signed |
| det | output | 1 | Metric above threshold |
| start_idx | output | 32 | Latest coarse start estimate |

## Verification
The sums are running totals, so a wrong add or subtract, or a wrong delay tap, never heals. It shows on `p_re`/`p_im` at the next output and on every output after it, until the next period change. A wrong fill count shows within 2L samples of a clear, either as `det` rising too early or as a step in P when stale history is subtracted. A fault in the handshake shows within a cycle as a lost, repeated or changed sample on `m_i`/`m_q`.

// File: rtl/ofdm_coarse_sync.sv
module ofdm_coarse_sync #(
  parameter int DW   = 16,
  parameter int LMIN = 16,
  parameter int NSEL = 6,
  parameter int TH_W = 8,
  parameter int IW   = 32,
  parameter int SW   = 4,
  localparam int PW  = 2*DW + 2 + $clog2(LMIN << (NSEL-1))
)(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SW-1:0]        len_code,
  input  logic [TH_W-1:0]      thr,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [DW-1:0] s_i,
  input  logic signed [DW-1:0] s_q,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [DW-1:0] m_i,
  output logic signed [DW-1:0] m_q,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im,
  output logic                 det,
  output logic [IW-1:0]        start_idx
);
  localparam int LMAX  = LMIN << (NSEL-1);
  localparam int DEPTH = 2*LMAX;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 1;
  localparam int MW    = 2*PW + TH_W + 2;

  logic [SW-1:0]        cur_code;
  logic [AW-1:0]        wp;
  logic [CW-1:0]        fill;
  logic [IW-1:0]        idx;
  logic signed [PW-1:0] acc_re, acc_im, acc_en;
  logic                 last_det;
  logic [2*DW-1:0]      hist [DEPTH];

  logic [CW-1:0] len, len2;
  always_comb begin
    len  = (cur_code >= SW'(NSEL-1)) ? CW'(LMAX) : (CW'(LMIN) << cur_code);
    len2 = {len[CW-2:0], 1'b0};
  end

  wire chg  = len_code != cur_code;
  assign s_ready = (!m_valid || m_ready) && !chg;
  wire take = s_valid && s_ready;

  wire [AW-1:0]   ra = wp - len[AW-1:0];
  wire [AW-1:0]   rb = wp - len2[AW-1:0];
  wire [2*DW-1:0] wa = (fill >= len)  ? hist[ra] : '0;
  wire [2*DW-1:0] wb = (fill >= len2) ? hist[rb] : '0;
  wire signed [DW-1:0] ai = wa[2*DW-1:DW];
  wire signed [DW-1:0] aq = wa[DW-1:0];
  wire signed [DW-1:0] bi = wb[2*DW-1:DW];
  wire signed [DW-1:0] bq = wb[DW-1:0];

  function automatic logic signed [PW-1:0] csum(
    input logic signed [DW-1:0] a, input logic signed [DW-1:0] b,
    input logic signed [DW-1:0] c, input logic signed [DW-1:0] d,
    input logic neg);
    logic signed [2*DW-1:0] x, y;
    logic signed [2*DW:0]   s;
    x = (2*DW)'(a) * (2*DW)'(b);
    y = (2*DW)'(c) * (2*DW)'(d);
    s = neg ? ({x[2*DW-1], x} - {y[2*DW-1], y}) : ({x[2*DW-1], x} + {y[2*DW-1], y});
    return {{(PW-2*DW-1){s[2*DW]}}, s};
  endfunction

  logic signed [PW-1:0] nre, nim, nen;
  logic signed [MW-1:0] pr, pi, rr, th, lhs, rhs;
  logic [CW-1:0]        fill_n;
  logic                 det_n;

  always_comb begin
    nre = acc_re + csum(ai, s_i, aq, s_q, 1'b0) - csum(bi, ai, bq, aq, 1'b0);
    nim = acc_im + csum(ai, s_q, aq, s_i, 1'b1) - csum(bi, aq, bq, ai, 1'b1);
    nen = acc_en + csum(s_i, s_i, s_q, s_q, 1'b0) - csum(ai, ai, aq, aq, 1'b0);
    pr  = MW'(nre);
    pi  = MW'(nim);
    rr  = MW'(nen);
    th  = MW'({1'b0, thr});
    lhs = (pr*pr + pi*pi) <<< TH_W;
    rhs = th * rr * rr;
    fill_n = (fill == len2) ? fill : fill + CW'(1);
    det_n  = (fill_n == len2) && (lhs > rhs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= '0;  wp <= '0;  fill <= '0;  idx <= '0;
      acc_re <= '0;  acc_im <= '0;  acc_en <= '0;  last_det <= 1'b0;
      m_valid <= 1'b0;  m_i <= '0;  m_q <= '0;
      p_re <= '0;  p_im <= '0;  det <= 1'b0;  start_idx <= '0;
    end else begin
      if (m_valid && m_ready) m_valid <= 1'b0;
      if (chg) begin
        cur_code <= len_code;
        fill <= '0;  idx <= '0;  last_det <= 1'b0;
        acc_re <= '0;  acc_im <= '0;  acc_en <= '0;
      end else if (take) begin
        wp <= wp + AW'(1);
        fill <= fill_n;
        idx <= idx + IW'(1);
        acc_re <= nre;  acc_im <= nim;  acc_en <= nen;
        last_det <= det_n;
        m_valid <= 1'b1;
        m_i <= s_i;  m_q <= s_q;
        p_re <= nre;  p_im <= nim;
        det <= det_n;
        if (det_n && !last_det) start_idx <= idx - IW'(len2) + IW'(1);
      end
    end
  end

  always_ff @(posedge clk)
    if (take) hist[wp] <= {s_i, s_q};

endmodule

// File: rtl/ofdm_coarse_sync_chk.sv
module ofdm_coarse_sync_chk #(
  parameter int DW   = 16,
  parameter int LMIN = 16,
  parameter int NSEL = 6,
  parameter int IW   = 32,
  parameter int SW   = 4,
  parameter int PW   = 43
)(
  input logic                 clk,
  input logic                 rst_n,
  input logic [SW-1:0]        len_code,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [DW-1:0] m_i,
  input logic signed [DW-1:0] m_q,
  input logic signed [PW-1:0] p_re,
  input logic signed [PW-1:0] p_im,
  input logic                 det,
  input logic [IW-1:0]        start_idx
);
  localparam int LMAX = LMIN << (NSEL-1);

  logic [SW-1:0] seen;
  logic [15:0]   cnt;
  logic          arm_ok;
  wire  [15:0]   need = (seen >= SW'(NSEL-1)) ? 16'(2*LMAX) : (16'(2*LMIN) << seen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= '0;  cnt <= '0;  arm_ok <= 1'b0;
    end else if (len_code != seen) begin
      seen <= len_code;  cnt <= '0;
    end else if (s_valid && s_ready) begin
      if (cnt != 16'hFFFF) cnt <= cnt + 16'd1;
      arm_ok <= (cnt + 16'd1) >= need;
    end
  end

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable({m_i, m_q, p_re, p_im, det, start_idx}));

  a_r7_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |-> !s_ready);

  a_r6_change_stall: assert property (@(posedge clk) disable iff (!rst_n)
    len_code != seen |-> !s_ready);

  a_r4_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && det |-> arm_ok);

  a_r4_nonzero_corr: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && det |-> (p_re != '0 || p_im != '0));

  a_r5_start_on_det: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(start_idx) |-> m_valid && det);
endmodule

bind ofdm_coarse_sync ofdm_coarse_sync_chk #(
  .DW(DW), .LMIN(LMIN), .NSEL(NSEL), .IW(IW), .SW(SW), .PW(PW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .len_code(len_code), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q), .p_re(p_re), .p_im(p_im),
  .det(det), .start_idx(start_idx)
);

// File: tb/sim_ofdm_coarse_sync.sv
module sim_ofdm_coarse_sync;
  localparam int PW = 43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] len_code = '0;
  logic [7:0] thr = 8'd128;
  logic s_valid = 1'b0;
  logic s_ready;
  logic signed [15:0] s_i = '0, s_q = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic signed [15:0] m_i, m_q;
  logic signed [PW-1:0] p_re, p_im;
  logic det;
  logic [31:0] start_idx;

  always #2 clk = ~clk;

  ofdm_coarse_sync u0 (
    .clk(clk), .rst_n(rst_n), .len_code(len_code), .thr(thr),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
    .p_re(p_re), .p_im(p_im), .det(det), .start_idx(start_idx)
  );

  typedef struct {
    int i; int q; longint pr; longint pi; bit d; longint st;
  } exp_t;

  int n_chk = 0, n_err = 0;
  exp_t expq[$];
  int hi[$], hq[$];
  int mcode = 0;
  bit mlast = 1'b0;
  longint mstart = 0;
  int det_seen = 0;
  int rdy_pct = 100;
  bit thr_rand = 1'b0;
  string ptag = "R2";
  string dtag = "R4";

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lval(input int code);
    return (code >= 5) ? 512 : (16 << code);
  endfunction

  function automatic longint gv(input int k, input bit isq);
    if (k < 0) return 0;
    return isq ? longint'(hq[k]) : longint'(hi[k]);
  endfunction

  function automatic void mpush(input int xi, input int xq, input int th);
    int n, L;
    longint pr, pim, r;
    logic signed [127:0] a, b, e, lhs, rhs;
    exp_t x;
    bit d;
    hi.push_back(xi);  hq.push_back(xq);
    n = hi.size() - 1;
    L = lval(mcode);
    pr = 0;  pim = 0;  r = 0;
    for (int k = n - L + 1; k <= n; k++) begin
      longint oi = gv(k - L, 0), oq = gv(k - L, 1), ni = gv(k, 0), nq = gv(k, 1);
      pr  += oi*ni + oq*nq;
      pim += oi*nq - oq*ni;
      r   += ni*ni + nq*nq;
    end
    a = pr;  b = pim;  e = r;
    lhs = (a*a + b*b) * 256;
    rhs = 128'(th) * e * e;
    d = (n + 1 >= 2*L) && (lhs > rhs);
    if (d && !mlast) mstart = n - 2*L + 1;
    mlast = d;
    x.i = xi;  x.q = xq;  x.pr = pr;  x.pi = pim;  x.d = d;  x.st = mstart;
    expq.push_back(x);
  endfunction

  task automatic eval(output bit took);
    bit er;
    exp_t x;
    #1;
    took = 1'b0;
    er = (!m_valid || m_ready) && (int'(len_code) == mcode);
    chk(s_ready == er, (int'(len_code) != mcode) ? "R6" : "R7", "s_ready", s_ready, er);
    chk(m_valid == (expq.size() != 0), "R7", "m_valid", m_valid, expq.size() != 0);
    if (m_valid && m_ready && expq.size() != 0) begin
      x = expq.pop_front();
      chk(m_i == 16'(x.i) && m_q == 16'(x.q), "R7", "sample i/q",
          {m_i, m_q}, {16'(x.i), 16'(x.q)});
      chk(longint'(p_re) == x.pr, ptag, "p_re", p_re, x.pr);
      chk(longint'(p_im) == x.pi, ptag, "p_im", p_im, x.pi);
      chk(det == x.d, dtag, "det", det, x.d);
      chk(longint'(start_idx) == x.st, "R5", "start_idx", start_idx, x.st);
      if (det) det_seen++;
    end
    if (int'(len_code) != mcode) begin
      hi.delete();  hq.delete();  mlast = 1'b0;  mcode = int'(len_code);
    end else if (s_valid && s_ready) begin
      mpush(int'(s_i), int'(s_q), int'(thr));
      took = 1'b1;
    end
  endtask

  task automatic send(input int xi, input int xq);
    bit took;
    s_valid = 1'b1;  s_i = 16'(xi);  s_q = 16'(xq);
    do begin
      m_ready = ($urandom_range(0, 99) < rdy_pct);
      if (thr_rand) thr = 8'($urandom_range(0, 255));
      eval(took);
      @(negedge clk);
    end while (!took);
    s_valid = 1'b0;
    if ($urandom_range(0, 9) == 0) begin
      m_ready = 1'b1;
      eval(took);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    bit took;
    for (int c = 0; c < n; c++) begin
      s_valid = 1'b0;  m_ready = 1'b1;
      eval(took);
      @(negedge clk);
    end
  endtask

  task automatic burst(input int code, input int nnoise, input int nper, input int amp);
    int L;
    len_code = 4'(code);
    idle(3);
    L = lval(code);
    for (int k = 0; k < nnoise; k++)
      send($urandom_range(0, 200) - 100, $urandom_range(0, 200) - 100);
    for (int k = 0; k < nper; k++) begin
      int j = k % L;
      send((((j*7 + 3) % 11) < 5) ? amp : -amp, (((j*5 + 1) % 13) < 6) ? amp : -amp);
    end
    idle(4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_valid == 1'b0, "R8", "m_valid after reset", m_valid, 0);
    chk(s_ready == 1'b1, "R8", "s_ready after reset", s_ready, 1);
    chk(det == 1'b0, "R8", "det after reset", det, 0);
    chk(start_idx == 32'd0, "R8", "start_idx after reset", start_idx, 0);
    @(negedge clk);

    det_seen = 0;
    burst(0, 50, 120, 3000);
    chk(det_seen > 0, "R4", "detections at L=16", det_seen, 1);

    rdy_pct = 40;  thr = 8'd200;
    det_seen = 0;
    burst(1, 70, 200, 1500);
    chk(det_seen > 0, "R4", "detections at L=32 with stalls", det_seen, 1);

    rdy_pct = 80;  thr_rand = 1'b1;  dtag = "R9";
    burst(2, 100, 300, 2000);
    thr_rand = 1'b0;  dtag = "R4";

    thr = 8'd0;
    burst(0, 40, 60, 500);
    thr = 8'd255;
    burst(0, 40, 60, 500);

    thr = 8'd128;  rdy_pct = 90;  ptag = "R3";
    det_seen = 0;
    burst(5, 0, 1100, 32767);
    for (int k = 0; k < 60; k++) send(-32768, -32768);
    chk(det_seen > 0, "R3", "detections at full scale L=512", det_seen, 1);

    ptag = "R1";
    det_seen = 0;
    burst(7, 20, 1080, 4000);
    chk(det_seen > 0, "R1", "detections with clamped code", det_seen, 1);

    ptag = "R6";
    len_code = 4'd3;
    s_valid = 1'b1;  s_i = 16'sd77;  s_q = -16'sd5;
    idle(1);
    burst(3, 10, 300, 1000);

    idle(5);
    chk(expq.size() == 0, "R7", "outputs left undelivered", expq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R7 watchdog: actual %0d cycles expected fewer", 150000);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule